// File: doc/BRIEF.md
# Unaligned Byte-Stream Word-Memory Mover

This block moves a run of bytes between a byte stream and a memory that is organised in 16-bit words. A transfer starts with one command that carries a byte address, a byte count and a direction. Writing into memory, the block takes bytes from an input stream. Reading from memory, it hands bytes out on an output stream. Both streams use a valid/ready handshake. The start address and the count may be odd. The block works out for itself which bytes of each word it touches.

When a write covers only one byte of a word, the block first reads that word and keeps the byte it does not own, then writes the merged word back. This happens for an odd start address and for a lone final byte at an even address. A word that is covered in full is written without a read. A memory error on any access stops the transfer at once. The block then raises a one-cycle completion flag with the error status set.

Top module: `dma_byte_aligner`

## Requirements
- R1: Byte order is little-endian. The byte at an even address sits in word bits 7:0, and the byte at the following odd address sits in bits 15:8.
- R2: A write that starts at an odd address first reads the containing word. It writes that word back with the original bits 7:0 and the first stream byte in bits 15:8.
- R3: When a write ends with one byte at an even address, the block reads that word. It writes the word back with the original bits 15:8 and the last stream byte in bits 7:0.
- R4: A word whose two bytes both come from the stream is written with no read access to that word.
- R5: A read that starts at an odd address emits bits 15:8 of the containing word as its first byte.
- R6: A read emits exactly the requested number of bytes. When the last byte sits at an even address, only bits 7:0 of the final word are emitted.
- R7: A start command with a count of zero, in either direction, raises `done` on the following cycle. It makes no memory access, and `done_err` is 0.
- R8: An access answered with `mem_ack` and `mem_err` both high ends the transfer. On the next cycle `done` and `done_err` are both 1, and after that no further memory access or stream handshake takes place.
- R9: Every memory access has address bit 0 at 0. Request, address, write flag and write data stay constant from the cycle the request rises until `mem_ack`.
- R10: A start command is taken only when the block is idle (`busy` and `done` both low). A start given during a transfer has no effect on memory, on the streams or on completion.
- R11: Each accepted command produces exactly one `done` pulse of one cycle. `done_err` is 0 for a transfer that ends without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the block releases it synchronously inside |
| start_vld | input | 1 | Start command strobe, taken only when idle |
| start_wr | input | 1 | Direction: 1 means stream to memory, 0 means memory to stream |
| start_addr | input | ADDR_W | Byte address of the first byte |
| start_len | input | LEN_W | Number of bytes to move |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Status shown with `done`: 1 means ended by a memory error |
| in_valid | input | 1 | Input stream byte valid |
| in_data | input | 8 | Input stream byte |
| in_ready | output | 1 | Block accepts an input byte |
| out_valid | output | 1 | Output stream byte valid |
| out_data | output | 8 | Output stream byte |
| out_ready | input | 1 | Consumer accepts the output byte |
| mem_req | output | 1 | Memory access request, held until `mem_ack` |
| mem_we | output | 1 | 1 means write, 0 means read |
| mem_addr | output | ADDR_W | Byte address of the word, bit 0 always 0 |
| mem_wdata | output | 16 | Word written |
| mem_ack | input | 1 | Access complete, one cycle |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| mem_rdata | input | 16 | Word read, valid with `mem_ack` |

## Verification
Writes are tried with four address patterns: even start and even count, odd start, even start with odd count, and a single byte at an odd address. A memory model counts reads, so a full-word write is told apart from a merge, and the words next to each one show whether kept bytes survive. Reads are tried with an even start, and with an odd start plus an odd end under alternating backpressure; this separates high-lane from low-lane selection and shows the byte count is exact. Error responses injected in the middle of a write and of a read show the abort. A zero-length command and a start given while a transfer is running show that no extra accesses or completions happen.

// File: rtl/dma_aln_pkg.sv
package dma_aln_pkg;
  localparam int unsigned LANES  = 2;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = LANES * BYTE_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COLLECT,
    ST_MERGE_RD,
    ST_WR,
    ST_FETCH,
    ST_EMIT,
    ST_DONE
  } aln_state_e;
endpackage

// File: rtl/dma_aln_track.sv
// Word pointer, byte lane and remaining-count bookkeeping for one transfer.
module dma_aln_track #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [LEN_W-1:0]  len_in,
  input  logic              byte_step,
  input  logic              word_step,
  output logic [ADDR_W-2:0] wptr,
  output logic              lane,
  output logic              last_byte,
  output logic              rem_zero
);
  logic [ADDR_W-2:0] wptr_q, wptr_d;
  logic              lane_q, lane_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic              en;

  assign en = load | byte_step | word_step;

  always_comb begin
    wptr_d = wptr_q;
    lane_d = lane_q;
    rem_d  = rem_q;
    if (load) begin
      wptr_d = addr_in[ADDR_W-1:1];
      lane_d = addr_in[0];
      rem_d  = len_in;
    end else begin
      if (byte_step) begin
        lane_d = ~lane_q;
        rem_d  = rem_q - 1'b1;
      end
      if (word_step) wptr_d = wptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      lane_q <= 1'b0;
      rem_q  <= '0;
    end else if (en) begin
      wptr_q <= wptr_d;
      lane_q <= lane_d;
      rem_q  <= rem_d;
    end
  end

  assign wptr      = wptr_q;
  assign lane      = lane_q;
  assign last_byte = (rem_q == LEN_W'(1));
  assign rem_zero  = (rem_q == '0);
endmodule

// File: rtl/dma_aln_lanes.sv
// Per-lane word buffer with ownership mask; merges read data into unowned lanes.
module dma_aln_lanes
  import dma_aln_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              put_byte,
  input  logic              lane,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              fill_rd,
  input  logic              take_word,
  input  logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] word_q,
  output logic [LANES-1:0]  mask_q,
  output logic [BYTE_W-1:0] out_byte
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] b_q, b_d;
    logic              m_q, m_d;
    logic              sel, en;

    assign sel = (lane == 1'(g));
    assign en  = clr | put_byte | fill_rd | take_word;

    always_comb begin
      b_d = b_q;
      m_d = m_q;
      if (clr) m_d = 1'b0;
      if (put_byte && sel) begin
        b_d = in_byte;
        m_d = 1'b1;
      end
      if (fill_rd && !m_q) b_d = rdata[g*BYTE_W +: BYTE_W];
      if (take_word)       b_d = rdata[g*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        b_q <= '0;
        m_q <= 1'b0;
      end else if (en) begin
        b_q <= b_d;
        m_q <= m_d;
      end
    end

    assign word_q[g*BYTE_W +: BYTE_W] = b_q;
    assign mask_q[g]                  = m_q;
  end

  assign out_byte = lane ? word_q[2*BYTE_W-1:BYTE_W] : word_q[BYTE_W-1:0];
endmodule

// File: rtl/dma_aln_fsm.sv
// Transfer sequencer: collects/emits bytes and issues word accesses.
module dma_aln_fsm
  import dma_aln_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_vld,
  input  logic start_wr,
  input  logic start_len_zero,
  input  logic in_valid,
  input  logic out_ready,
  input  logic mem_ack,
  input  logic mem_err,
  input  logic lane,
  input  logic last_byte,
  input  logic rem_zero,
  input  logic mask_lo,
  output logic load,
  output logic byte_step,
  output logic word_step,
  output logic put_byte,
  output logic fill_rd,
  output logic take_word,
  output logic in_ready,
  output logic out_valid,
  output logic mem_req,
  output logic mem_we,
  output logic busy,
  output logic done,
  output logic done_err
);
  aln_state_e st_q, st_d;
  logic       err_q, err_d;

  always_comb begin
    st_d      = st_q;
    err_d     = err_q;
    load      = 1'b0;
    byte_step = 1'b0;
    word_step = 1'b0;
    put_byte  = 1'b0;
    fill_rd   = 1'b0;
    take_word = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_vld) begin
          load  = 1'b1;
          err_d = 1'b0;
          if (start_len_zero) st_d = ST_DONE;
          else if (start_wr)  st_d = ST_COLLECT;
          else                st_d = ST_FETCH;
        end
      end
      ST_COLLECT: begin
        if (in_valid) begin
          put_byte  = 1'b1;
          byte_step = 1'b1;
          if (lane || last_byte)
            st_d = (lane && mask_lo) ? ST_WR : ST_MERGE_RD;
        end
      end
      ST_MERGE_RD: begin
        if (mem_ack) begin
          if (mem_err) begin
            err_d = 1'b1;
            st_d  = ST_DONE;
          end else begin
            fill_rd = 1'b1;
            st_d    = ST_WR;
          end
        end
      end
      ST_WR: begin
        if (mem_ack) begin
          if (mem_err) begin
            err_d = 1'b1;
            st_d  = ST_DONE;
          end else if (rem_zero) begin
            st_d = ST_DONE;
          end else begin
            word_step = 1'b1;
            st_d      = ST_COLLECT;
          end
        end
      end
      ST_FETCH: begin
        if (mem_ack) begin
          if (mem_err) begin
            err_d = 1'b1;
            st_d  = ST_DONE;
          end else begin
            take_word = 1'b1;
            st_d      = ST_EMIT;
          end
        end
      end
      ST_EMIT: begin
        if (out_ready) begin
          byte_step = 1'b1;
          if (last_byte) begin
            st_d = ST_DONE;
          end else if (lane) begin
            word_step = 1'b1;
            st_d      = ST_FETCH;
          end
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
    end
  end

  assign in_ready  = (st_q == ST_COLLECT);
  assign out_valid = (st_q == ST_EMIT);
  assign mem_req   = (st_q == ST_MERGE_RD) || (st_q == ST_WR) || (st_q == ST_FETCH);
  assign mem_we    = (st_q == ST_WR);
  assign busy      = (st_q != ST_IDLE) && (st_q != ST_DONE);
  assign done      = (st_q == ST_DONE);
  assign done_err  = done & err_q;
endmodule

// File: rtl/dma_byte_aligner.sv
module dma_byte_aligner #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_vld,
  input  logic              start_wr,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  start_len,
  output logic              busy,
  output logic              done,
  output logic              done_err,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [7:0]        out_data,
  input  logic              out_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [15:0]       mem_rdata
);
  import dma_aln_pkg::*;

  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic              load, byte_step, word_step, put_byte, fill_rd, take_word;
  logic [ADDR_W-2:0] wptr;
  logic              lane, last_byte, rem_zero;
  logic [WORD_W-1:0] word_q;
  logic [LANES-1:0]  mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  dma_aln_track #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .load      (load),
    .addr_in   (start_addr),
    .len_in    (start_len),
    .byte_step (byte_step),
    .word_step (word_step),
    .wptr      (wptr),
    .lane      (lane),
    .last_byte (last_byte),
    .rem_zero  (rem_zero)
  );

  dma_aln_lanes u_lanes (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .clr       (load | word_step),
    .put_byte  (put_byte),
    .lane      (lane),
    .in_byte   (in_data),
    .fill_rd   (fill_rd),
    .take_word (take_word),
    .rdata     (mem_rdata),
    .word_q    (word_q),
    .mask_q    (mask_q),
    .out_byte  (out_data)
  );

  dma_aln_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_core_n),
    .start_vld      (start_vld),
    .start_wr       (start_wr),
    .start_len_zero (start_len == '0),
    .in_valid       (in_valid),
    .out_ready      (out_ready),
    .mem_ack        (mem_ack),
    .mem_err        (mem_err),
    .lane           (lane),
    .last_byte      (last_byte),
    .rem_zero       (rem_zero),
    .mask_lo        (mask_q[0]),
    .load           (load),
    .byte_step      (byte_step),
    .word_step      (word_step),
    .put_byte       (put_byte),
    .fill_rd        (fill_rd),
    .take_word      (take_word),
    .in_ready       (in_ready),
    .out_valid      (out_valid),
    .mem_req        (mem_req),
    .mem_we         (mem_we),
    .busy           (busy),
    .done           (done),
    .done_err       (done_err)
  );

  assign mem_addr  = {wptr, 1'b0};
  assign mem_wdata = word_q;
endmodule

// File: rtl/dma_byte_aligner_chk.sv
module dma_byte_aligner_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LEN_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_vld,
  input logic [LEN_W-1:0]  start_len,
  input logic              busy,
  input logic              done,
  input logic              done_err,
  input logic              in_ready,
  input logic              out_valid,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [15:0]       mem_wdata,
  input logic              mem_ack,
  input logic              mem_err
);
  a_r9_even_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_addr[0]);

  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_err) |=> (done && done_err));

  a_r8_quiet_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_req && !in_ready && !out_valid && !busy));

  a_r7_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    (start_vld && !busy && !done && start_len == '0) |=> (done && !done_err && !mem_req));

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind dma_byte_aligner dma_byte_aligner_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .start_vld (start_vld),
  .start_len (start_len),
  .busy      (busy),
  .done      (done),
  .done_err  (done_err),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack),
  .mem_err   (mem_err)
);

// File: tb/dma_byte_aligner_test.sv
`timescale 1ns/100ps
module dma_byte_aligner_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_vld = 1'b0, start_wr = 1'b0;
  logic [15:0] start_addr = '0;
  logic [11:0] start_len = '0;
  logic        busy, done, done_err;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, out_valid, out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        mem_req, mem_we;
  logic [15:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0, mem_err = 1'b0;
  logic [15:0] mem_rdata = '0;

  int total = 0, bad = 0;
  int done_cnt = 0;
  bit last_err = 0;
  int rd_cnt = 0, wr_cnt = 0, acc_cnt = 0;
  bit odd_seen = 0;
  bit err_en = 0;
  logic [5:0]  err_word = '0;
  logic [15:0] mem [0:63];
  logic [7:0]  src [0:15];
  logic [7:0]  dst [0:15];

  always #2.5 clk = ~clk;

  dma_byte_aligner uut (.*);

  function automatic logic [15:0] pat(input int i);
    return {8'(i + 8'h40), 8'(8'hC0 - i)};
  endfunction

  // memory model: one access per request, acknowledged for one cycle
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      mem_err = 1'b0;
    end else if (mem_req) begin
      if (mem_addr[0]) odd_seen = 1;
      acc_cnt++;
      mem_ack = 1'b1;
      if (err_en && mem_addr[6:1] == err_word) mem_err = 1'b1;
      else if (mem_we) begin mem[mem_addr[6:1]] = mem_wdata; wr_cnt++; end
      else begin mem_rdata = mem[mem_addr[6:1]]; rd_cnt++; end
    end
  end

  always @(negedge clk) if (done) begin done_cnt++; last_err = done_err; end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_stats();
    rd_cnt = 0; wr_cnt = 0; acc_cnt = 0;
    for (int i = 0; i < 64; i++) mem[i] = pat(i);
  endtask

  task automatic run_write(input logic [15:0] a, input int n, output int acc, output bit e);
    int k, d0;
    d0 = done_cnt; k = 0;
    start_addr = a; start_len = 12'(n); start_wr = 1; start_vld = 1;
    @(negedge clk); start_vld = 0;
    while (k < n && done_cnt == d0) begin
      in_data = src[k]; in_valid = 1;
      if (in_ready) k++;
      @(negedge clk);
    end
    in_valid = 0;
    while (done_cnt == d0) @(negedge clk);
    acc = k; e = last_err;
    @(negedge clk);
  endtask

  task automatic run_read(input logic [15:0] a, input int n, input bit throttle, output int got, output bit e);
    int d0, cyc;
    d0 = done_cnt; got = 0; cyc = 0;
    start_addr = a; start_len = 12'(n); start_wr = 0; start_vld = 1;
    @(negedge clk); start_vld = 0;
    while (done_cnt == d0) begin
      out_ready = throttle ? cyc[0] : 1'b1;
      if (out_valid && out_ready && got < 16) begin dst[got] = out_data; got++; end
      cyc++;
      @(negedge clk);
    end
    out_ready = 0; e = last_err;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !mem_req && !in_ready && !out_valid, "R11", "idle after reset",
        {busy, done, mem_req, in_ready, out_valid}, 0);
  endtask

  task automatic t_wr_aligned();
    int acc; bit e;
    clear_stats();
    src[0] = 8'h11; src[1] = 8'h22; src[2] = 8'h33; src[3] = 8'h44;
    run_write(16'h0008, 4, acc, e);
    chk(mem[4] == 16'h2211, "R1", "word4", mem[4], 16'h2211);
    chk(mem[5] == 16'h4433, "R1", "word5", mem[5], 16'h4433);
    chk(rd_cnt == 0, "R4", "reads for full words", rd_cnt, 0);
    chk(mem[3] == pat(3) && mem[6] == pat(6), "R1", "neighbours", mem[6], pat(6));
    chk(!e, "R11", "status ok", e, 0);
  endtask

  task automatic t_wr_odd_start();
    int acc; bit e;
    clear_stats();
    mem[10] = 16'hBEEF;
    src[0] = 8'hA1; src[1] = 8'hA2; src[2] = 8'hA3;
    run_write(16'h0015, 3, acc, e);
    chk(mem[10] == 16'hA1EF, "R2", "odd head merge", mem[10], 16'hA1EF);
    chk(mem[11] == 16'hA3A2, "R4", "full word after head", mem[11], 16'hA3A2);
    chk(rd_cnt == 1 && wr_cnt == 2, "R2", "one read two writes", rd_cnt * 16 + wr_cnt, 18);
  endtask

  task automatic t_wr_odd_tail();
    int acc; bit e;
    clear_stats();
    mem[17] = 16'hCAFE;
    src[0] = 8'h01; src[1] = 8'h02; src[2] = 8'h03;
    run_write(16'h0020, 3, acc, e);
    chk(mem[16] == 16'h0201, "R1", "word16", mem[16], 16'h0201);
    chk(mem[17] == 16'hCA03, "R3", "even tail merge", mem[17], 16'hCA03);
    chk(rd_cnt == 1, "R3", "tail read", rd_cnt, 1);
  endtask

  task automatic t_wr_single_odd();
    int acc; bit e;
    clear_stats();
    mem[24] = 16'h1234;
    src[0] = 8'h5A;
    run_write(16'h0031, 1, acc, e);
    chk(mem[24] == 16'h5A34, "R2", "single odd byte", mem[24], 16'h5A34);
    chk(mem[25] == pat(25), "R2", "next word untouched", mem[25], pat(25));
  endtask

  task automatic t_zero_len();
    bit seen;
    clear_stats();
    start_addr = 16'h0044; start_len = 0; start_wr = 1; start_vld = 1;
    @(negedge clk); start_vld = 0;
    seen = done && !done_err;
    chk(seen, "R7", "zero-length write done next cycle", done, 1);
    repeat (3) @(negedge clk);
    start_wr = 0; start_vld = 1;
    @(negedge clk); start_vld = 0;
    chk(done && !done_err, "R7", "zero-length read done next cycle", done, 1);
    repeat (3) @(negedge clk);
    chk(acc_cnt == 0, "R7", "no memory access", acc_cnt, 0);
  endtask

  task automatic t_rd_aligned();
    int got; bit e;
    clear_stats();
    mem[32] = 16'hB2B1; mem[33] = 16'hB4B3;
    run_read(16'h0040, 4, 0, got, e);
    chk(got == 4, "R6", "byte count", got, 4);
    chk({dst[0], dst[1], dst[2], dst[3]} == 32'hB1B2B3B4, "R1", "read order",
        {dst[0], dst[1], dst[2], dst[3]}, 32'hB1B2B3B4);
  endtask

  task automatic t_rd_odd();
    int got; bit e;
    clear_stats();
    mem[33] = 16'hC2C1; mem[34] = 16'hC4C3; mem[35] = 16'hC6C5;
    run_read(16'h0043, 4, 1, got, e);
    chk(got == 4, "R6", "odd read count", got, 4);
    chk(dst[0] == 8'hC2, "R5", "first byte high lane", dst[0], 8'hC2);
    chk({dst[1], dst[2], dst[3]} == 24'hC3C4C5, "R6", "tail low lane only",
        {dst[1], dst[2], dst[3]}, 24'hC3C4C5);
    chk(rd_cnt == 3 && !e, "R6", "word reads", rd_cnt, 3);
  endtask

  task automatic t_wr_error();
    int acc; bit e;
    clear_stats();
    err_en = 1; err_word = 6'h29;
    for (int i = 0; i < 6; i++) src[i] = 8'(8'h70 + i);
    run_write(16'h0050, 6, acc, e);
    err_en = 0;
    chk(e, "R8", "write error status", e, 1);
    chk(acc == 4, "R8", "bytes taken before abort", acc, 4);
    chk(mem[40] == 16'h7170 && mem[41] == pat(41) && mem[42] == pat(42), "R8",
        "no write past error", mem[42], pat(42));
    repeat (4) @(negedge clk);
    chk(acc_cnt == 2 && !busy, "R8", "no access after abort", acc_cnt, 2);
  endtask

  task automatic t_rd_error();
    int got; bit e;
    clear_stats();
    err_en = 1; err_word = 6'h31;
    run_read(16'h0060, 6, 0, got, e);
    err_en = 0;
    chk(e && got == 2, "R8", "read abort bytes", got, 2);
  endtask

  task automatic t_start_busy();
    int d0, acc; bit e;
    clear_stats();
    d0 = done_cnt;
    start_addr = 16'h0070; start_len = 2; start_wr = 1; start_vld = 1;
    @(negedge clk);
    start_addr = 16'h007E; start_len = 2; start_wr = 0;
    @(negedge clk); start_vld = 0;
    src[0] = 8'h3C; src[1] = 8'h4D;
    for (int k = 0; k < 2;) begin
      in_data = src[k]; in_valid = 1;
      if (in_ready) k++;
      @(negedge clk);
    end
    in_valid = 0;
    repeat (10) @(negedge clk);
    chk(mem[56] == 16'h4D3C, "R10", "first command result", mem[56], 16'h4D3C);
    chk(rd_cnt == 0 && mem[63] == pat(63), "R10", "second start ignored", rd_cnt, 0);
    chk(done_cnt - d0 == 1, "R11", "single done pulse", done_cnt - d0, 1);
    chk(!odd_seen, "R9", "even word addresses", odd_seen, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clear_stats();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_wr_aligned();
    t_wr_odd_start();
    t_wr_odd_tail();
    t_wr_single_odd();
    t_zero_len();
    t_rd_aligned();
    t_rd_odd();
    t_wr_error();
    t_rd_error();
    t_start_busy();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule